// File: doc/BRIEF.md
# Signed multiply and divide unit with a low-half extension register

This unit does 32-bit signed multiplication and division for a core that keeps an extra "low half" register, called MQ here. A product is split across the destination and MQ. In long division the dividend is assembled from the first operand and MQ. Every divide leaves its remainder in MQ, and when the record flag is set the condition nibble is taken from that remainder, not from the quotient.

Each operation starts with a one-cycle start pulse that captures the following:
- the operation code;
- the two operands;
- the current MQ value;
- the incoming OV and SO flags;
- the overflow-enable flag;
- the record flag.

A multiply finishes one clock edge after it is captured. A divide uses a restoring magnitude divider with one quotient bit per cycle, followed by a sign-correction cycle. A one-cycle done pulse marks the moment all outputs are valid. The outputs then hold their values until the next done pulse.

Top module: `md_unit`

## Requirements
- R1: While reset is asserted and after its release, until the first done pulse, done is low and rd_out, mq_out, ov_out, so_out, cr0_out and cr0_valid are all zero.
- R2: The operation codes are 0 = multiply, 1 = long divide, 2 = short divide, and 3 = a second code for multiply. A multiply forms the signed 64-bit product of ra and rb. The upper 32 bits go to rd_out and the lower 32 bits go to mq_out. done rises on the first clock edge after the edge that captured start.
- R3: For a multiply with ov_en set, ov_out is 1 exactly when the product falls outside the signed 32-bit range. so_out is the captured SO ORed with that overflow. Op code 3 gives results identical to op code 0.
- R4: A long divide divides the signed 64-bit value {ra, mq_in} by the signed rb, truncating toward zero. rd_out gets the low 32 bits of the quotient. mq_out gets the remainder, which carries the sign of the dividend. With ov_en set, OV is 1 exactly when the quotient does not fit in signed 32 bits, and SO becomes SO OR OV. done rises 2*W+1 edges after the capturing edge.
- R5: A long divide by zero gives rd_out = 0x80000000 and mq_out = 0. The dividend {0xFFFFFFFF, 0x80000000} divided by -1 gives the same two values. With ov_en set, both cases set OV and SO.
- R6: A short divide computes ra / rb as signed 32-bit values, truncating toward zero. The remainder, with the sign of ra, goes to mq_out. With ov_en set and a non-zero divisor other than the min/-1 case, OV is cleared and SO is left at its captured value.
- R7: A short divide by zero gives rd_out = 0xFFFFFFFF and mq_out = ra. 0x80000000 divided by 0xFFFFFFFF gives rd_out = 0x80000000 and mq_out = 0. With ov_en set, both cases set OV and SO.
- R8: With ov_en clear, ov_out and so_out equal the ov_in and so_in values captured at start, whatever the operation produces.
- R9: With the record flag set, cr0_valid is 1 and cr0_out is {LT, GT, EQ, SO}, bit 3 down to bit 0. LT, GT and EQ compare a signed source value with zero: for a multiply the source is the low product half, and for a divide it is the remainder. SO equals so_out. With the record flag clear, cr0_valid and cr0_out are 0.
- R10: done lasts one cycle. The outputs change only on the edge that raises done. A start pulse that arrives while an operation is in progress is ignored. A start sampled on the edge after done rises is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture operands and begin an operation |
| op | input | 2 | Operation code |
| ov_en | input | 1 | Allow the operation to update OV and SO |
| rec_en | input | 1 | Produce a condition nibble |
| ra | input | W | First operand, upper dividend half for long divide |
| rb | input | W | Second operand or divisor |
| mq_in | input | W | Current MQ value |
| ov_in | input | 1 | Current OV flag |
| so_in | input | 1 | Current SO flag |
| done | output | 1 | One-cycle pulse: outputs valid |
| rd_out | output | W | Destination value |
| mq_out | output | W | New MQ value |
| ov_out | output | 1 | New OV flag |
| so_out | output | 1 | New SO flag |
| cr0_out | output | 4 | Condition nibble {LT, GT, EQ, SO} |
| cr0_valid | output | 1 | Record flag of the finished operation |

## Verification
The hardest situation to reach is a long-divide dividend whose 64-bit quotient overflows while its low word still looks plausible. Examples are {0x00000001, 0} divided by 2 and {0x80000000, 0} divided by -1; the second also stresses the magnitude path at its most negative value. The stimulus builds these dividends directly through mq_in and ra. It also fires a second start in the middle of a divide, and another on the edge right after done, to probe the busy boundary from both sides. A seeded random mix of all four op codes then runs against the behavioural model, which checks done and every output on each clock.

// File: rtl/md_pkg.sv
package md_pkg;
  typedef enum logic [1:0] {
    MD_MUL  = 2'd0,
    MD_DIVL = 2'd1,
    MD_DIVS = 2'd2,
    MD_MULA = 2'd3
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_DIV  = 2'd2,
    ST_FIX  = 2'd3
  } md_st_e;
endpackage

// File: rtl/md_mul.sv
module md_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod,
  output logic           ovf
);
  localparam int W2 = 2 * W;

  logic signed [W2-1:0] a_ext;
  logic signed [W2-1:0] b_ext;
  logic signed [W2-1:0] p_full;
  logic [W:0]           top_bits;

  always_comb begin
    a_ext    = $signed({{W{a[W-1]}}, a});
    b_ext    = $signed({{W{b[W-1]}}, b});
    p_full   = a_ext * b_ext;
    prod     = p_full;
    top_bits = prod[W2-1:W-1];
    ovf      = !((top_bits == '0) || (top_bits == '1));
  end
endmodule

// File: rtl/md_div_iter.sv
module md_div_iter #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [2*W-1:0] dvd,
  input  logic [W-1:0]   dvs,
  output logic [2*W-1:0] quo_mag,
  output logic [W-1:0]   rem_mag,
  output logic           q_neg,
  output logic           r_neg
);
  localparam int W2 = 2 * W;

  logic [W2-1:0] q_acc_q, q_acc_d;
  logic [W-1:0]  r_acc_q, r_acc_d;
  logic [W-1:0]  d_acc_q, d_acc_d;
  logic          qn_q, qn_d, rn_q, rn_d;
  logic [W2-1:0] dvd_mag;
  logic [W-1:0]  dvs_mag;
  logic [W:0]    shifted;
  logic [W:0]    diff;

  always_comb begin
    dvd_mag = dvd[W2-1] ? (~dvd + 1'b1) : dvd;
    dvs_mag = dvs[W-1] ? (~dvs + 1'b1) : dvs;
    shifted = {r_acc_q, q_acc_q[W2-1]};
    diff    = shifted - {1'b0, d_acc_q};
    q_acc_d = q_acc_q;
    r_acc_d = r_acc_q;
    d_acc_d = d_acc_q;
    qn_d    = qn_q;
    rn_d    = rn_q;
    if (load) begin
      q_acc_d = dvd_mag;
      r_acc_d = '0;
      d_acc_d = dvs_mag;
      qn_d    = dvd[W2-1] ^ dvs[W-1];
      rn_d    = dvd[W2-1];
    end else if (step) begin
      if (!diff[W]) begin
        r_acc_d = diff[W-1:0];
        q_acc_d = {q_acc_q[W2-2:0], 1'b1};
      end else begin
        r_acc_d = shifted[W-1:0];
        q_acc_d = {q_acc_q[W2-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_acc_q <= '0;
      r_acc_q <= '0;
      d_acc_q <= '0;
      qn_q    <= 1'b0;
      rn_q    <= 1'b0;
    end else if (load || step) begin
      q_acc_q <= q_acc_d;
      r_acc_q <= r_acc_d;
      d_acc_q <= d_acc_d;
      qn_q    <= qn_d;
      rn_q    <= rn_d;
    end
  end

  assign quo_mag = q_acc_q;
  assign rem_mag = r_acc_q;
  assign q_neg   = qn_q;
  assign r_neg   = rn_q;
endmodule

// File: rtl/md_div_fix.sv
module md_div_fix #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] quo_mag,
  input  logic [W-1:0]   rem_mag,
  input  logic           q_neg,
  input  logic           r_neg,
  input  logic           dvs_zero,
  input  logic           is_short,
  input  logic [W-1:0]   ra_val,
  output logic [W-1:0]   rd,
  output logic [W-1:0]   mq,
  output logic           ovf
);
  localparam int W2 = 2 * W;

  logic [W2-1:0] q_s;
  logic [W-1:0]  r_s;
  logic [W:0]    q_top;

  always_comb begin
    q_s   = q_neg ? (~quo_mag + 1'b1) : quo_mag;
    r_s   = r_neg ? (~rem_mag + 1'b1) : rem_mag;
    q_top = q_s[W2-1:W-1];
    if (dvs_zero && is_short) begin
      rd  = '1;
      mq  = ra_val;
      ovf = 1'b1;
    end else if (dvs_zero) begin
      rd  = {1'b1, {(W-1){1'b0}}};
      mq  = '0;
      ovf = 1'b1;
    end else begin
      rd  = q_s[W-1:0];
      mq  = r_s;
      ovf = !((q_top == '0) || (q_top == '1));
    end
  end
endmodule

// File: rtl/md_flags.sv
module md_flags #(
  parameter int W = 32
) (
  input  logic         ovf,
  input  logic         ov_en,
  input  logic         ov_in,
  input  logic         so_in,
  input  logic         rec_en,
  input  logic [W-1:0] cr_src,
  output logic         ov,
  output logic         so,
  output logic [3:0]   cr0
);
  logic src_neg, src_zero;

  always_comb begin
    src_neg  = cr_src[W-1];
    src_zero = (cr_src == '0);
    ov       = ov_en ? ovf : ov_in;
    so       = ov_en ? (so_in | ovf) : so_in;
    cr0      = rec_en ? {src_neg, !src_neg && !src_zero, src_zero, so} : 4'd0;
  end
endmodule

// File: rtl/md_unit.sv
module md_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic         ov_en,
  input  logic         rec_en,
  input  logic [W-1:0] ra,
  input  logic [W-1:0] rb,
  input  logic [W-1:0] mq_in,
  input  logic         ov_in,
  input  logic         so_in,
  output logic         done,
  output logic [W-1:0] rd_out,
  output logic [W-1:0] mq_out,
  output logic         ov_out,
  output logic         so_out,
  output logic [3:0]   cr0_out,
  output logic         cr0_valid
);
  import md_pkg::*;

  localparam int W2 = 2 * W;
  localparam int CW = $clog2(W2);
  localparam logic [CW-1:0] LAST = CW'(W2 - 1);

  md_st_e        state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  md_op_e        op_in, op_q;
  logic          oven_q, rec_q, ovin_q, soin_q;
  logic [W-1:0]  ra_q, rb_q;
  logic          accept, is_div_in, finish, is_mul_st;
  logic [W2-1:0] dvd_in;

  logic [W2-1:0] prod;
  logic          mul_ovf;
  logic [W2-1:0] quo_mag;
  logic [W-1:0]  rem_mag;
  logic          q_neg, r_neg;
  logic [W-1:0]  div_rd, div_mq;
  logic          div_ovf;
  logic [W-1:0]  res_rd, res_mq, cr_src;
  logic          res_ovf, nx_ov, nx_so;
  logic [3:0]    nx_cr0;

  logic          done_q;
  logic [W-1:0]  rd_q, mq_q;
  logic          ov_q, so_q, crv_q;
  logic [3:0]    cr0_q;

  assign op_in     = md_op_e'(op);
  assign accept    = (state_q == ST_IDLE) && start;
  assign is_div_in = (op_in == MD_DIVL) || (op_in == MD_DIVS);
  assign dvd_in    = (op_in == MD_DIVS) ? {{W{ra[W-1]}}, ra} : {ra, mq_in};
  assign is_mul_st = (state_q == ST_MUL);
  assign finish    = is_mul_st || (state_q == ST_FIX);

  md_mul #(.W(W)) mul_i (
    .a    (ra_q),
    .b    (rb_q),
    .prod (prod),
    .ovf  (mul_ovf)
  );

  md_div_iter #(.W(W)) div_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept && is_div_in),
    .step    (state_q == ST_DIV),
    .dvd     (dvd_in),
    .dvs     (rb),
    .quo_mag (quo_mag),
    .rem_mag (rem_mag),
    .q_neg   (q_neg),
    .r_neg   (r_neg)
  );

  md_div_fix #(.W(W)) fix_i (
    .quo_mag  (quo_mag),
    .rem_mag  (rem_mag),
    .q_neg    (q_neg),
    .r_neg    (r_neg),
    .dvs_zero (rb_q == '0),
    .is_short (op_q == MD_DIVS),
    .ra_val   (ra_q),
    .rd       (div_rd),
    .mq       (div_mq),
    .ovf      (div_ovf)
  );

  always_comb begin
    res_rd  = is_mul_st ? prod[W2-1:W] : div_rd;
    res_mq  = is_mul_st ? prod[W-1:0]  : div_mq;
    res_ovf = is_mul_st ? mul_ovf      : div_ovf;
    cr_src  = res_mq;
  end

  md_flags #(.W(W)) flags_i (
    .ovf    (res_ovf),
    .ov_en  (oven_q),
    .ov_in  (ovin_q),
    .so_in  (soin_q),
    .rec_en (rec_q),
    .cr_src (cr_src),
    .ov     (nx_ov),
    .so     (nx_so),
    .cr0    (nx_cr0)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = is_div_in ? ST_DIV : ST_MUL;
          cnt_d   = '0;
        end
      end
      ST_MUL: state_d = ST_IDLE;
      ST_DIV: begin
        if (cnt_q == LAST) state_d = ST_FIX;
        else               cnt_d   = cnt_q + 1'b1;
      end
      ST_FIX: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= finish;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= MD_MUL;
      oven_q <= 1'b0;
      rec_q  <= 1'b0;
      ovin_q <= 1'b0;
      soin_q <= 1'b0;
      ra_q   <= '0;
      rb_q   <= '0;
    end else if (accept) begin
      op_q   <= op_in;
      oven_q <= ov_en;
      rec_q  <= rec_en;
      ovin_q <= ov_in;
      soin_q <= so_in;
      ra_q   <= ra;
      rb_q   <= rb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      mq_q  <= '0;
      ov_q  <= 1'b0;
      so_q  <= 1'b0;
      cr0_q <= 4'd0;
      crv_q <= 1'b0;
    end else if (finish) begin
      rd_q  <= res_rd;
      mq_q  <= res_mq;
      ov_q  <= nx_ov;
      so_q  <= nx_so;
      cr0_q <= nx_cr0;
      crv_q <= rec_q;
    end
  end

  assign done      = done_q;
  assign rd_out    = rd_q;
  assign mq_out    = mq_q;
  assign ov_out    = ov_q;
  assign so_out    = so_q;
  assign cr0_out   = cr0_q;
  assign cr0_valid = crv_q;
endmodule

// File: rtl/md_unit_chk.sv
module md_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         done,
  input logic [W-1:0] rd_out,
  input logic [W-1:0] mq_out,
  input logic         so_out,
  input logic [3:0]   cr0_out,
  input logic         cr0_valid
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_out) |-> done);

  // R10
  mq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mq_out) |-> done);

  // R9
  cr0_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cr0_valid) |-> (cr0_out[0] == so_out));

  // R9
  cr0_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cr0_valid) |-> ($countones(cr0_out[3:1]) == 1));

  // R9
  cr0_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cr0_valid |-> (cr0_out == 4'd0));
endmodule

bind md_unit md_unit_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .rd_out    (rd_out),
  .mq_out    (mq_out),
  .so_out    (so_out),
  .cr0_out   (cr0_out),
  .cr0_valid (cr0_valid)
);

// File: tb/md_unit_tb_top.sv
`timescale 1ns/1ps
module md_unit_tb_top;
  localparam int LAT_MUL = 1;
  localparam int LAT_DIV = 65;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        ov_en = 1'b0;
  logic        rec_en = 1'b0;
  logic [31:0] ra = '0, rb = '0, mq_in = '0;
  logic        ov_in = 1'b0, so_in = 1'b0;
  logic        done;
  logic [31:0] rd_out, mq_out;
  logic        ov_out, so_out, cr0_valid;
  logic [3:0]  cr0_out;

  always #2.5 clk = ~clk;

  md_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .ov_en(ov_en),
    .rec_en(rec_en), .ra(ra), .rb(rb), .mq_in(mq_in), .ov_in(ov_in),
    .so_in(so_in), .done(done), .rd_out(rd_out), .mq_out(mq_out),
    .ov_out(ov_out), .so_out(so_out), .cr0_out(cr0_out), .cr0_valid(cr0_valid)
  );

  typedef struct {
    int          due;
    logic [31:0] rd;
    logic [31:0] mq;
    logic        ov;
    logic        so;
    logic [3:0]  cr;
    logic        crv;
    string       tag;
  } exp_t;

  exp_t        pend[$];
  int          cyc = 0;
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;
  logic [31:0] m_rd = '0, m_mq = '0;
  logic        m_ov = 0, m_so = 0, m_crv = 0;
  logic [3:0]  m_cr = '0;
  string       m_tag = "R1";

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h cyc=%0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !finished) begin
      bit exp_done;
      exp_done = (pend.size() > 0) && (pend[0].due == cyc);
      if (exp_done) begin
        m_rd = pend[0].rd; m_mq = pend[0].mq; m_ov = pend[0].ov;
        m_so = pend[0].so; m_cr = pend[0].cr; m_crv = pend[0].crv;
        m_tag = pend[0].tag;
        void'(pend.pop_front());
      end
      chk(exp_done ? m_tag : "R10", "done", {31'd0, done}, {31'd0, exp_done});
      chk(m_tag, "rd_out", rd_out, m_rd);
      chk(m_tag, "mq_out", mq_out, m_mq);
      chk(m_tag, "ov_out", {31'd0, ov_out}, {31'd0, m_ov});
      chk(m_tag, "so_out", {31'd0, so_out}, {31'd0, m_so});
      chk(m_tag, "cr0_out", {28'd0, cr0_out}, {28'd0, m_cr});
      chk(m_tag, "cr0_valid", {31'd0, cr0_valid}, {31'd0, m_crv});
    end
  end

  function automatic exp_t model(logic [1:0] o, logic oe, logic re, logic [31:0] a,
                                 logic [31:0] b, logic [31:0] m, logic oi, logic si,
                                 string tag);
    exp_t e;
    longint p, dvd, d, qv, rv;
    logic ovf;
    logic [31:0] src;
    e.tag = tag;
    if (o == 2'd0 || o == 2'd3) begin
      p = longint'($signed(a)) * longint'($signed(b));
      e.rd = p[63:32]; e.mq = p[31:0];
      ovf = (p > 64'sd2147483647) || (p < -64'sd2147483648);
    end else if (o == 2'd1) begin
      if (b == 0) begin
        e.rd = 32'h80000000; e.mq = 0; ovf = 1;
      end else if (a == 32'h80000000 && m == 0 && b == 32'hFFFFFFFF) begin
        e.rd = 32'h0; e.mq = 0; ovf = 1;
      end else begin
        dvd = {a, m};
        d = longint'($signed(b));
        qv = dvd / d; rv = dvd % d;
        e.rd = qv[31:0]; e.mq = rv[31:0];
        ovf = (qv > 64'sd2147483647) || (qv < -64'sd2147483648);
      end
    end else begin
      if (b == 0) begin
        e.rd = 32'hFFFFFFFF; e.mq = a; ovf = 1;
      end else begin
        dvd = longint'($signed(a));
        d = longint'($signed(b));
        qv = dvd / d; rv = dvd % d;
        e.rd = qv[31:0]; e.mq = rv[31:0];
        ovf = (qv > 64'sd2147483647);
      end
    end
    e.ov = oe ? ovf : oi;
    e.so = oe ? (si | ovf) : si;
    src = e.mq;
    e.cr = re ? {src[31], !src[31] && (src != 0), src == 0, e.so} : 4'd0;
    e.crv = re;
    return e;
  endfunction

  task automatic issue(logic [1:0] o, logic oe, logic re, logic [31:0] a, logic [31:0] b,
                       logic [31:0] m, logic oi, logic si, string tag);
    exp_t e;
    bit acc;
    @(posedge clk); #1;
    start = 1; op = o; ov_en = oe; rec_en = re; ra = a; rb = b; mq_in = m;
    ov_in = oi; so_in = si;
    acc = (pend.size() == 0) || (pend[pend.size()-1].due <= cyc + 1);
    if (acc) begin
      e = model(o, oe, re, a, b, m, oi, si, tag);
      e.due = cyc + 2 + ((o == 2'd1 || o == 2'd2) ? LAT_DIV : LAT_MUL);
      pend.push_back(e);
    end
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic run(logic [1:0] o, logic oe, logic re, logic [31:0] a, logic [31:0] b,
                     logic [31:0] m, logic oi, logic si, string tag);
    issue(o, oe, re, a, b, m, oi, si, tag);
    while (pend.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(negedge clk);           // R1: reset state compared each clock
    // R2 multiply
    run(2'd0, 1, 1, 32'd5, 32'd7, 0, 0, 0, "R2");
    run(2'd0, 1, 1, 32'hFFFFFFFD, 32'd1000, 0, 0, 0, "R2");
    run(2'd0, 0, 0, 32'h12345678, 32'h9ABCDEF0, 0, 0, 0, "R2");
    // R3 multiply overflow, op 3 alias
    run(2'd0, 1, 1, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 0, 0, "R3");
    run(2'd3, 1, 1, 32'h80000000, 32'h80000000, 0, 0, 0, "R3");
    run(2'd3, 1, 1, 32'hFFFFFFFF, 32'd1, 0, 1, 1, "R3");
    // R8 ov_en clear
    run(2'd0, 0, 1, 32'h7FFFFFFF, 32'd4, 0, 0, 0, "R8");
    run(2'd1, 0, 1, 32'd0, 32'd0, 32'd9, 1, 0, "R8");
    // R4 long divide
    run(2'd1, 1, 1, 32'd0, 32'd7, 32'd100, 0, 0, "R4");
    run(2'd1, 1, 1, 32'hFFFFFFFF, 32'd7, 32'hFFFFFF9C, 0, 1, "R4");
    run(2'd1, 1, 1, 32'd1, 32'd2, 32'd0, 0, 0, "R4");
    run(2'd1, 1, 0, 32'h00000003, 32'hFFFFFFF0, 32'h21, 1, 0, "R4");
    run(2'd1, 1, 1, 32'h80000000, 32'hFFFFFFFF, 32'd0, 0, 0, "R4");
    // R5 long divide specials
    run(2'd1, 1, 1, 32'h1234, 32'd0, 32'h5678, 0, 0, "R5");
    run(2'd1, 1, 1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h80000000, 0, 0, "R5");
    // R6 short divide
    run(2'd2, 1, 1, 32'd100, 32'hFFFFFFF9, 0, 1, 1, "R6");
    run(2'd2, 1, 1, 32'hFFFFFF9C, 32'd7, 0, 0, 0, "R6");
    run(2'd2, 1, 1, 32'd42, 32'd6, 0, 0, 0, "R6");
    // R7 short divide specials
    run(2'd2, 1, 1, 32'hFFFFFFF5, 32'd0, 0, 0, 0, "R7");
    run(2'd2, 1, 1, 32'h80000000, 32'hFFFFFFFF, 0, 0, 0, "R7");
    // R9 record nibble cases
    run(2'd0, 1, 1, 32'd0, 32'd77, 0, 0, 1, "R9");
    run(2'd2, 1, 1, 32'd9, 32'd4, 0, 0, 0, "R9");
    // R10 start while busy is ignored, start on done edge accepted
    issue(2'd1, 1, 1, 32'd0, 32'd3, 32'd1000, 0, 0, "R10");
    repeat (10) @(posedge clk);
    issue(2'd0, 1, 1, 32'd11, 32'd13, 0, 0, 0, "R10");
    while (pend.size() > 0) @(negedge clk);
    issue(2'd0, 1, 1, 32'd3, 32'd4, 0, 0, 0, "R10");
    issue(2'd0, 1, 1, 32'hFFFFFFF0, 32'd4, 0, 0, 0, "R10");
    while (pend.size() > 0) @(negedge clk);
    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [31:0] x, y, z;
      logic [1:0] o;
      x = $urandom; y = $urandom; z = $urandom; o = 2'($urandom);
      if (i % 5 == 0) y = {{24{y[7]}}, y[7:0]};
      run(o, 1'($urandom), 1'($urandom), x, y, z, 1'($urandom), 1'($urandom),
          (o == 2'd1) ? "R4" : (o == 2'd2) ? "R6" : "R2");
    end
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule